// File: doc/BRIEF.md
# Latched Battery Health Monitor

This block reports the condition of the primary backup cell on two active-low flags: a battery-low warning and a battery-fail alarm. Two digitized comparator results feed it. One says the cell is under the low threshold and the other says it is under the fail threshold. A third input is the power-fail indication from the supply supervisor. All three inputs arrive asynchronously and pass through a synchronizer of configurable depth.

The cell is graded only once per powered period. The grade is taken at the moment the supply is seen to return, which is the falling edge of the synchronized power-fail signal. The grade is kept internally while a recovery delay runs. It is then shown on the flags and stays frozen until the supply fails again. While power is failed, and during the recovery delay, both flags read inactive (high). A power failure that arrives during the delay throws the pending grade away, and the next return of power takes a new sample. Leaving reset counts as being powered down. If the supply is already good after reset, that is treated as a power-up crossing.

Top module: `battery_health_monitor`

## Requirements
- R1: While `rst_n` is low and just after it is released, `batt_low_n` and `batt_fail_n` are both 1.
- R2: While the synchronized power-fail signal is 1, both flags are 1.
- R3: The grade comes from the synchronized comparator values present at the power-up crossing. Comparator changes after that crossing, including changes during the recovery delay, do not alter it.
- R4: After a power-up crossing, the flags take the latched grade on the rising edge that falls SYNC_STAGES + RECOVERY_CYCLES cycles after the first rising edge that samples `pwr_fail` low. Before that edge both flags stay 1.
- R5: A sample with `cell_below_low`=1 and `cell_below_fail`=0 shows as `batt_low_n`=0 and `batt_fail_n`=1.
- R6: A sample with `cell_below_fail`=1 shows as both flags 0, whatever the value of `cell_below_low`. `batt_fail_n`=0 never occurs while `batt_low_n`=1.
- R7: A sample with both comparator inputs 0 shows as both flags 1.
- R8: Once shown, the flags stay constant until the power-fail input is seen high.
- R9: If `pwr_fail` is seen high during the recovery delay, the pending grade is dropped. The next power-up takes a fresh sample and restarts the full delay.
- R10: When `pwr_fail` rises while the flags are shown, both flags return to 1 on the rising edge SYNC_STAGES cycles after the first edge that samples `pwr_fail` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Supply below the power-fail threshold (1 = failed), asynchronous |
| cell_below_low | input | 1 | Primary cell under the low threshold, asynchronous |
| cell_below_fail | input | 1 | Primary cell under the fail threshold, asynchronous |
| batt_low_n | output | 1 | Battery-low flag, active low |
| batt_fail_n | output | 1 | Battery-fail flag, active low |

## Verification
A wrong latched grade stays hidden during the recovery delay. It becomes visible on the exact edge where the flags should appear and then stays wrong for the whole powered period. That makes the release edge the place to compare. A timer that is off by one moves that edge by one cycle. A missed cancel shows as flags that appear too early after the second power-up, or that carry the stale grade. Because the bench compares the flags on every cycle, any of these faults is caught within one cycle of where the outputs first differ.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  typedef enum logic [1:0] {
    GRADE_OK   = 2'd0,
    GRADE_LOW  = 2'd1,
    GRADE_FAIL = 2'd2
  } cell_grade_e;

  // Fail dominates: a fail reading implies a low cell even if the low
  // comparator disagrees.
  function automatic cell_grade_e grade_of(input logic below_low, input logic below_fail);
    cell_grade_e g;
    if (below_fail)     g = GRADE_FAIL;
    else if (below_low) g = GRADE_LOW;
    else                g = GRADE_OK;
    return g;
  endfunction

  function automatic logic low_flag_n(input cell_grade_e g, input logic shown);
    return !(shown && (g != GRADE_OK));
  endfunction

  function automatic logic fail_flag_n(input cell_grade_e g, input logic shown);
    return !(shown && (g == GRADE_FAIL));
  endfunction

endpackage

// File: rtl/hbm_sync.sv
module hbm_sync #(
  parameter int          WIDTH     = 1,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RESET_VAL;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RESET_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hbm_recovery_timer.sv
module hbm_recovery_timer #(
  parameter int DELAY = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pf_s,
  input  logic start,
  output logic pending,
  output logic shown
);

  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      shown   <= 1'b0;
      cnt     <= '0;
    end else if (pf_s) begin
      pending <= 1'b0;
      shown   <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      pending <= 1'b1;
      cnt     <= '0;
    end else if (pending) begin
      if (cnt == LAST) begin
        pending <= 1'b0;
        shown   <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: a failed supply always withdraws the display on the next edge
  assert_fail_hides_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_s |=> !shown);
  // R4: display only starts from a pending delay with good supply
  assert_show_from_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shown) |-> $past(pending) && !$past(pf_s));
  // R4: counter never passes the delay limit
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R9: pending and shown are exclusive
  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending && shown));

endmodule

// File: rtl/hbm_grade_latch.sv
module hbm_grade_latch
  import hbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic        below_low,
  input  logic        below_fail,
  output cell_grade_e grade
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       grade <= GRADE_OK;
    else if (capture) grade <= grade_of(below_low, below_fail);
  end

  // R3: the grade moves only at a capture
  assert_grade_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(grade));
  // R6: a fail reading at capture yields the fail grade
  assert_fail_grade_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && below_fail) |=> (grade == GRADE_FAIL));

endmodule

// File: rtl/battery_health_monitor.sv
module battery_health_monitor
  import hbm_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int RECOVERY_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic cell_below_low,
  input  logic cell_below_fail,
  output logic batt_low_n,
  output logic batt_fail_n
);

  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] SYNC_RST = 3'b100; // {pwr_fail, low, fail}

  logic [NSIG-1:0] raw_in, sync_out;
  logic            pf_s, low_s, fail_s;
  logic            pf_q;
  logic            pu_evt;
  logic            pending, shown;
  cell_grade_e     grade;

  assign raw_in = {pwr_fail, cell_below_low, cell_below_fail};

  hbm_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign pf_s   = sync_out[2];
  assign low_s  = sync_out[1];
  assign fail_s = sync_out[0];

  // Previous synchronized supply state; reset treats the part as powered down.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pf_q <= 1'b1;
    else        pf_q <= pf_s;
  end

  assign pu_evt = pf_q && !pf_s;

  hbm_grade_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (pu_evt),
    .below_low  (low_s),
    .below_fail (fail_s),
    .grade      (grade)
  );

  hbm_recovery_timer #(.DELAY(RECOVERY_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .pf_s    (pf_s),
    .start   (pu_evt),
    .pending (pending),
    .shown   (shown)
  );

  assign batt_low_n  = low_flag_n(grade, shown);
  assign batt_fail_n = fail_flag_n(grade, shown);

  // R1: flags inactive during reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (batt_low_n && batt_fail_n));
  // R2: flags inactive the cycle after a synchronized power failure
  assert_pf_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_s |=> (batt_low_n && batt_fail_n));
  // R6: a fail flag never appears without the low flag
  assert_fail_implies_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_fail_n |-> !batt_low_n);
  // R8: shown flags are frozen while the supply stays good
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shown && !pf_s) |=> ($stable(batt_low_n) && $stable(batt_fail_n)));
  // R9: a new crossing only happens with nothing on display
  assert_fresh_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pu_evt |-> !shown);

endmodule

// File: tb/battery_health_monitor_test.sv
`timescale 1ns/1ps
module battery_health_monitor_test;

  localparam int S = 2;
  localparam int D = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b1;
  logic cell_below_low = 1'b0;
  logic cell_below_fail = 1'b0;
  logic batt_low_n, batt_fail_n;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  string tag  = "R1";

  always #2.5 clk = ~clk;

  battery_health_monitor #(.SYNC_STAGES(S), .RECOVERY_CYCLES(D)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .pwr_fail        (pwr_fail),
    .cell_below_low  (cell_below_low),
    .cell_below_fail (cell_below_fail),
    .batt_low_n      (batt_low_n),
    .batt_fail_n     (batt_fail_n)
  );

  // Behavioural reference: delay queue for synchronizer, integers for state.
  logic [2:0] mq[$];
  bit m_prev_pf = 1, m_pf = 1, m_low = 0, m_fail = 0;
  bit m_pend = 0, m_shown = 0;
  int m_cnt = 0, m_grade = 0;

  initial for (int i = 0; i < S; i++) mq.push_back(3'b100);

  always @(posedge clk) begin
    bit ev;
    logic [2:0] v;
    if (!rst_n) begin
      mq.delete();
      for (int i = 0; i < S; i++) mq.push_back(3'b100);
      m_prev_pf = 1; m_pf = 1; m_low = 0; m_fail = 0;
      m_pend = 0; m_shown = 0; m_cnt = 0; m_grade = 0;
    end else begin
      ev = m_prev_pf && !m_pf;
      if (ev) m_grade = m_fail ? 2 : (m_low ? 1 : 0);
      if (m_pf) begin
        m_pend = 0; m_shown = 0;
      end else if (ev) begin
        m_pend = 1; m_cnt = 0;
      end else if (m_pend) begin
        if (m_cnt == D - 1) begin m_shown = 1; m_pend = 0; end
        else m_cnt++;
      end
      m_prev_pf = m_pf;
      mq.push_back({pwr_fail, cell_below_low, cell_below_fail});
      void'(mq.pop_front());
      v = mq[0];
      m_pf = v[2]; m_low = v[1]; m_fail = v[0];
    end
  end

  always @(negedge clk) begin
    logic el, ef;
    if (!done) begin
      el = !(m_shown && m_grade >= 1);
      ef = !(m_shown && m_grade == 2);
      vectors++;
      if (batt_low_n !== el || batt_fail_n !== ef) begin
        errors++;
        $display("FAIL %s cycle compare: low_n=%b fail_n=%b expected low_n=%b fail_n=%b",
                 tag, batt_low_n, batt_fail_n, el, ef);
      end
    end
  end

  task automatic check(input string rq, input logic el, input logic ef);
    vectors++;
    if (batt_low_n !== el || batt_fail_n !== ef) begin
      errors++;
      $display("FAIL %s directed: low_n=%b fail_n=%b expected low_n=%b fail_n=%b",
               rq, batt_low_n, batt_fail_n, el, ef);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drop pwr_fail with given cell inputs; check the release edge exactly.
  task automatic power_up(input string rq, input logic lo, input logic fa,
                          input logic el, input logic ef);
    cell_below_low = lo; cell_below_fail = fa;
    cyc(S + 2);
    pwr_fail = 1'b0;
    cyc(S + D);
    check("R4", 1'b1, 1'b1);
    cyc(1);
    check(rq, el, ef);
  endtask

  task automatic power_down(input logic el, input logic ef);
    pwr_fail = 1'b1;
    cyc(S);
    check("R8", el, ef);
    cyc(1);
    check("R10", 1'b1, 1'b1);
  endtask

  initial begin
    tag = "R1";
    cyc(4);
    check("R1", 1'b1, 1'b1);
    rst_n = 1'b1;
    cyc(1);
    check("R1", 1'b1, 1'b1);
    tag = "R2";
    cyc(10);
    check("R2", 1'b1, 1'b1);

    tag = "R5";
    power_up("R5", 1'b1, 1'b0, 1'b0, 1'b1);
    tag = "R8";
    cell_below_low = 1'b0; cell_below_fail = 1'b1;
    cyc(20);
    check("R8", 1'b0, 1'b1);
    tag = "R10";
    power_down(1'b0, 1'b1);
    tag = "R2";
    cyc(8);
    check("R2", 1'b1, 1'b1);

    tag = "R6";
    power_up("R6", 1'b1, 1'b1, 1'b0, 1'b0);
    power_down(1'b0, 1'b0);
    power_up("R6", 1'b0, 1'b1, 1'b0, 1'b0);
    power_down(1'b0, 1'b0);

    tag = "R7";
    power_up("R7", 1'b0, 1'b0, 1'b1, 1'b1);
    cell_below_low = 1'b1; cell_below_fail = 1'b1;
    cyc(15);
    check("R8", 1'b1, 1'b1);
    power_down(1'b1, 1'b1);

    // R3: comparators move during the delay; crossing sample must win.
    tag = "R3";
    cell_below_low = 1'b1; cell_below_fail = 1'b0;
    cyc(S + 2);
    pwr_fail = 1'b0;
    cyc(S + 3);
    cell_below_low = 1'b0;
    cell_below_fail = 1'b1;
    cyc(D - 3);
    check("R4", 1'b1, 1'b1);
    cyc(1);
    check("R3", 1'b0, 1'b1);
    power_down(1'b0, 1'b1);

    // R9: fail during delay cancels; fresh sample with full delay.
    tag = "R9";
    cell_below_low = 1'b1; cell_below_fail = 1'b1;
    cyc(S + 2);
    pwr_fail = 1'b0;
    cyc(D / 2);
    pwr_fail = 1'b1;
    cyc(5);
    cell_below_low = 1'b0; cell_below_fail = 1'b0;
    cyc(S + 2);
    pwr_fail = 1'b0;
    cyc(D / 2 + 5);
    check("R9", 1'b1, 1'b1);
    cyc(D / 2 - 5 + S - 1);
    check("R9", 1'b1, 1'b1);
    cell_below_low = 1'b1;
    cyc(1);
    check("R9", 1'b1, 1'b1);
    power_down(1'b1, 1'b1);

    // R4 with a power-up straight out of a fresh reset
    tag = "R4";
    rst_n = 1'b0;
    cell_below_low = 1'b1; cell_below_fail = 1'b0;
    pwr_fail = 1'b0;
    cyc(3);
    check("R1", 1'b1, 1'b1);
    rst_n = 1'b1;
    cyc(S + D + 3);
    check("R4", 1'b0, 1'b1);
    cyc(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule